// File: doc/BRIEF.md
# 4x4 Residual Block Reconstruction Engine

This engine rebuilds one 4x4 block of 8-bit pixels. Its inputs are sixteen signed quantized transform coefficients and sixteen unsigned prediction samples. Both sets are written through one indexed load port. A single start pulse then runs three phases under one state machine:

- **Scaling.** Every coefficient is scaled in parallel by a position-dependent factor. The quantizer setting is fixed.
- **Inverse transform.** A shared 1-D integer butterfly is applied to each of the four rows, then to each of the four columns, one line per cycle.
- **Reconstruction.** In the final cycle the rounded residual is added to the prediction and saturated to the 8-bit range.

The sixteen reconstructed pixels appear on a flat output bus with a done flag. Done stays high until the next accepted start.

A typical user loads a block, pulses start, waits for done and reads the pixels. The coefficient and prediction stores keep their contents between runs. Only the indices written again change.

Top module: `blk_recon4`

## Requirements
- R1: While reset is high and in the first cycle after it, busy and done are 0 and every output pixel is 0.
- R2: A load writes coefficient `load_coef` (signed 16-bit) and prediction `load_pred` (unsigned 8-bit) to position `load_idx`. The position is `4*row + col`. Output pixel k sits on bits `[8k+7:8k]` of `pix_out`, with k = `4*row + col`.
- R3: Each coefficient is scaled by V×8. V is 13 when row and column are both even, 20 when both are odd, and 16 otherwise.
- R4: The 1-D butterfly on (a,b,c,d) computes the following. It runs over all four rows first, then over all four columns, on signed values at least 16 bits wide.
  - e0=a+c
  - e1=a-c
  - e2=(b>>>1)-d
  - e3=b+(d>>>1)
  - outputs, in order: e0+e3, e1+e2, e1-e2, e0-e3
- R5: Each output pixel is prediction + ((x+32)>>>6), clamped to 0..255. Here x is the transformed value at that position and the shift is arithmetic.
- R6: A block whose coefficients are all zero reproduces the prediction exactly.
- R7: Timing of a run:
  - The edge that samples start is edge 1.
  - Busy is high from that edge on.
  - Done rises and busy falls at edge 11.
  - The pixel outputs change only at the edge where done rises.
- R8: Done stays high until an idle-time start is sampled. At that edge done clears and busy rises.
- R9: A start pulse while busy is ignored. The run finishes at its original edge with its original result.
- R10: A load while busy is ignored. The stored coefficient and prediction are unchanged, as a later run shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write one coefficient/prediction pair |
| load_idx | input | 4 | Position 4*row+col of the pair |
| load_coef | input | 16 | Signed quantized coefficient |
| load_pred | input | 8 | Unsigned prediction sample |
| start | input | 1 | Begin reconstruction of the stored block |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Output pixels valid |
| pix_out | output | 128 | Sixteen 8-bit pixels, pixel k at [8k+7:8k] |

## Verification
The embedded properties assume three things about the inputs:
- start and load are sampled only at clock edges;
- a start arriving in the final reconstruction cycle has no defined meaning;
- reset is applied before the first run.

The stimulus respects these assumptions. It drives inputs half a period away from the active edge, and it injects stray starts and loads only in the middle of the transform phases. Coefficients stay within signed 16 bits, so every intermediate stays within the 32-bit working width. The bench also sweeps the DC coefficient, places a single non-zero coefficient at every position with both signs, applies saturating extremes, and runs random blocks.

// File: rtl/blk_recon4_pkg.sv
package blk_recon4_pkg;

    localparam int GRID      = 4;
    localparam int QP_FIXED  = 20;
    localparam int QP_SHIFT  = QP_FIXED / 6;
    localparam int V_EVEN    = 13;
    localparam int V_ODD     = 20;
    localparam int V_MIXED   = 16;
    localparam int RND_SHIFT = 6;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SCALE,
        PH_ROWS,
        PH_COLS,
        PH_RECON
    } phase_e;

    // Scale factor for the coefficient at (row, col) at the fixed quantizer.
    function automatic int vscale(input int row, input int col);
        if ((row % 2 == 0) && (col % 2 == 0)) return V_EVEN;
        if ((row % 2 == 1) && (col % 2 == 1)) return V_ODD;
        return V_MIXED;
    endfunction

endpackage

// File: rtl/blk_dequant.sv
module blk_dequant #(
    parameter int COEF_W = 16,
    parameter int ACC_W  = 32,
    parameter int NPIX   = 16
) (
    input  logic signed [COEF_W-1:0] coef [NPIX],
    output logic signed [ACC_W-1:0]  dq   [NPIX]
);
    import blk_recon4_pkg::*;

    for (genvar g = 0; g < NPIX; g++) begin : g_scale
        localparam int MULT = vscale(g / GRID, g % GRID) * (1 << QP_SHIFT);
        logic signed [ACC_W-1:0] ext;
        assign ext   = {{(ACC_W-COEF_W){coef[g][COEF_W-1]}}, coef[g]};
        assign dq[g] = ext * $signed(ACC_W'(MULT));
    end

endmodule

// File: rtl/blk_bfly4.sv
module blk_bfly4 #(
    parameter int W = 32
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    input  logic signed [W-1:0] c,
    input  logic signed [W-1:0] d,
    output logic signed [W-1:0] y0,
    output logic signed [W-1:0] y1,
    output logic signed [W-1:0] y2,
    output logic signed [W-1:0] y3
);
    logic signed [W-1:0] s_sum, s_dif, s_odd_lo, s_odd_hi;

    assign s_sum    = a + c;
    assign s_dif    = a - c;
    assign s_odd_lo = (b >>> 1) - d;
    assign s_odd_hi = b + (d >>> 1);

    assign y0 = s_sum + s_odd_hi;
    assign y1 = s_dif + s_odd_lo;
    assign y2 = s_dif - s_odd_lo;
    assign y3 = s_sum - s_odd_hi;

endmodule

// File: rtl/blk_sat_add.sv
module blk_sat_add #(
    parameter int ACC_W = 32,
    parameter int PIX_W = 8,
    parameter int RSH   = 6
) (
    input  logic signed [ACC_W-1:0] res,
    input  logic        [PIX_W-1:0] pred,
    output logic        [PIX_W-1:0] pix
);
    localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1 << (RSH - 1));
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << PIX_W) - 1);

    logic signed [ACC_W-1:0] rounded, total;

    assign rounded = (res + RND) >>> RSH;
    assign total   = rounded + $signed({{(ACC_W-PIX_W){1'b0}}, pred});

    always_comb begin
        if (total < 0)
            pix = '0;
        else if (total > MAXV)
            pix = '1;
        else
            pix = total[PIX_W-1:0];
    end

endmodule

// File: rtl/blk_recon4.sv
module blk_recon4 #(
    parameter int COEF_W = 16,
    parameter int PIX_W  = 8,
    parameter int ACC_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_en,
    input  logic [3:0]              load_idx,
    input  logic [COEF_W-1:0]       load_coef,
    input  logic [PIX_W-1:0]        load_pred,
    input  logic                    start,
    output logic                    busy,
    output logic                    done,
    output logic [16*PIX_W-1:0]     pix_out
);
    import blk_recon4_pkg::*;

    localparam int NPIX  = GRID * GRID;
    localparam int LN_W  = $clog2(GRID);
    localparam int IDX_W = 2 * LN_W;

    phase_e                   phase;
    logic [LN_W-1:0]          line;
    logic                     done_r;
    logic signed [COEF_W-1:0] coef_q [NPIX];
    logic [PIX_W-1:0]         pred_q [NPIX];
    logic signed [ACC_W-1:0]  work   [NPIX];
    logic signed [ACC_W-1:0]  dq     [NPIX];
    logic [PIX_W-1:0]         pix_d  [NPIX];
    logic [PIX_W-1:0]         pix_q  [NPIX];
    logic [IDX_W-1:0]         sel    [GRID];
    logic signed [ACC_W-1:0]  bf_in  [GRID];
    logic signed [ACC_W-1:0]  bf_out [GRID];

    // Phase 1: parallel scaling of all coefficients
    blk_dequant #(.COEF_W(COEF_W), .ACC_W(ACC_W), .NPIX(NPIX)) u_dequant (
        .coef (coef_q),
        .dq   (dq)
    );

    // Line selection: row-major in the row pass, column-major in the column pass
    for (genvar g = 0; g < GRID; g++) begin : g_sel
        assign sel[g]   = (phase == PH_COLS) ? {LN_W'(g), line} : {line, LN_W'(g)};
        assign bf_in[g] = work[sel[g]];
    end

    // Phase 2: one shared 1-D butterfly, one line per cycle
    blk_bfly4 #(.W(ACC_W)) u_bfly (
        .a  (bf_in[0]),
        .b  (bf_in[1]),
        .c  (bf_in[2]),
        .d  (bf_in[3]),
        .y0 (bf_out[0]),
        .y1 (bf_out[1]),
        .y2 (bf_out[2]),
        .y3 (bf_out[3])
    );

    // Phase 3: rounding, prediction add and saturation for every pixel
    for (genvar g = 0; g < NPIX; g++) begin : g_sat
        blk_sat_add #(.ACC_W(ACC_W), .PIX_W(PIX_W), .RSH(RND_SHIFT)) u_sat (
            .res  (work[g]),
            .pred (pred_q[g]),
            .pix  (pix_d[g])
        );
        assign pix_out[g*PIX_W +: PIX_W] = pix_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            line   <= '0;
            done_r <= 1'b0;
            for (int k = 0; k < NPIX; k++) begin
                coef_q[k] <= '0;
                pred_q[k] <= '0;
                work[k]   <= '0;
                pix_q[k]  <= '0;
            end
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (load_en) begin
                        coef_q[load_idx] <= $signed(load_coef);
                        pred_q[load_idx] <= load_pred;
                    end
                    if (start) begin
                        phase  <= PH_SCALE;
                        done_r <= 1'b0;
                    end
                end
                PH_SCALE: begin
                    for (int k = 0; k < NPIX; k++) work[k] <= dq[k];
                    line  <= '0;
                    phase <= PH_ROWS;
                end
                PH_ROWS, PH_COLS: begin
                    for (int j = 0; j < GRID; j++) work[sel[j]] <= bf_out[j];
                    line <= line + 1'b1;
                    if (line == LN_W'(GRID - 1))
                        phase <= (phase == PH_ROWS) ? PH_COLS : PH_RECON;
                end
                PH_RECON: begin
                    for (int k = 0; k < NPIX; k++) pix_q[k] <= pix_d[k];
                    done_r <= 1'b1;
                    phase  <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase != PH_IDLE);
    assign done = done_r;

    // R7: a run in progress never shows done
    p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R7: pixels only move on the edge where done rises
    p_pix_stable_r7: assert property (@(posedge clk) disable iff (rst)
        !$rose(done) |-> $stable(pix_out));

    // R8: done holds while no start arrives
    p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done);

    // R8: an idle start clears done and opens a run
    p_start_accept_r8: assert property (@(posedge clk) disable iff (rst)
        !busy && start |=> busy && !done);

    // R9: a start inside a run before its last phase keeps the run going
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        busy && start && phase != PH_RECON |=> busy);

endmodule

// File: tb/blk_recon4_bench.sv
`timescale 1ns/1ps
module blk_recon4_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_en = 1'b0;
    logic [3:0]   load_idx = '0;
    logic [15:0]  load_coef = '0;
    logic [7:0]   load_pred = '0;
    logic         start = 1'b0;
    logic         busy, done;
    logic [127:0] pix_out;

    int checks = 0;
    int errors = 0;
    int cf [16];
    int pr [16];
    int ex [16];
    bit finished = 0;

    always #2.5 clk = ~clk;

    blk_recon4 u_blk_recon4 (
        .clk(clk), .rst(rst), .load_en(load_en), .load_idx(load_idx),
        .load_coef(load_coef), .load_pred(load_pred), .start(start),
        .busy(busy), .done(done), .pix_out(pix_out)
    );

    function automatic void bfly(inout int a, inout int b, inout int c, inout int d);
        int e0, e1, e2, e3;
        e0 = a + c; e1 = a - c; e2 = (b >>> 1) - d; e3 = b + (d >>> 1);
        a = e0 + e3; b = e1 + e2; c = e1 - e2; d = e0 - e3;
    endfunction

    function automatic void model();
        int w [16];
        for (int k = 0; k < 16; k++) begin
            int r, c, v;
            r = k / 4; c = k % 4;
            v = (r % 2 == 0 && c % 2 == 0) ? 13 : (r % 2 == 1 && c % 2 == 1) ? 20 : 16;
            w[k] = cf[k] * v * 8;
        end
        for (int r = 0; r < 4; r++) bfly(w[r*4], w[r*4+1], w[r*4+2], w[r*4+3]);
        for (int c = 0; c < 4; c++) bfly(w[c], w[4+c], w[8+c], w[12+c]);
        for (int k = 0; k < 16; k++) begin
            int s;
            s = pr[k] + ((w[k] + 32) >>> 6);
            ex[k] = (s < 0) ? 0 : (s > 255) ? 255 : s;
        end
    endfunction

    task automatic load_all();
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            load_en = 1'b1; load_idx = 4'(k);
            load_coef = 16'(cf[k]); load_pred = 8'(pr[k]);
        end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    // Runs a block; inj/ldj pick the count at which a stray start/load is driven (0 = none).
    task automatic run_blk(output int lat, input int inj, input int ldj);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            start   = (lat == inj);
            load_en = (lat == ldj);
            if (lat == ldj) begin
                load_idx = 4'd5; load_coef = 16'd999; load_pred = 8'd3;
            end
            @(posedge clk); #1;
            lat++;
        end
        start = 1'b0; load_en = 1'b0;
    endtask

    task automatic chk_pix(input string tag);
        int bad;
        bad = -1;
        model();
        for (int k = 0; k < 16; k++)
            if (bad < 0 && pix_out[8*k +: 8] != 8'(ex[k])) bad = k;
        checks++;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s pixel %0d actual %0d expected %0d", tag, bad,
                     pix_out[8*bad +: 8], ex[bad]);
        end
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int lat;
        logic [127:0] snap;
        repeat (3) @(posedge clk);
        #1;
        chk(busy == 0 && done == 0 && pix_out == '0, "R1 reset state", int'(done), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        chk(busy == 0 && done == 0 && pix_out == '0, "R1 after release", int'(busy), 0);

        // R6: all-zero coefficients with a ramp prediction; R7 latency
        for (int k = 0; k < 16; k++) begin cf[k] = 0; pr[k] = k * 16 + 7; end
        load_all();
        run_blk(lat, 0, 0);
        chk(lat == 11, "R7 latency", lat, 11);
        chk(busy == 0, "R7 busy falls", int'(busy), 0);
        chk_pix("R6 zero block");

        // R3: near-exhaustive DC sweep
        for (int dc = -200; dc <= 200; dc++) begin
            for (int k = 0; k < 16; k++) begin cf[k] = 0; pr[k] = 100 + k; end
            cf[0] = dc;
            load_all();
            run_blk(lat, 0, 0);
            chk_pix("R3 DC sweep");
        end

        // R2/R3/R4: single coefficient at every position, both signs
        for (int p = 0; p < 16; p++) begin
            for (int s = 0; s < 2; s++) begin
                for (int k = 0; k < 16; k++) begin cf[k] = 0; pr[k] = 128; end
                cf[p] = s ? -9 : 11;
                load_all();
                run_blk(lat, 0, 0);
                chk_pix("R2 R4 single coefficient");
            end
        end

        // R5: saturation at both ends
        for (int k = 0; k < 16; k++) begin cf[k] = (k % 3 == 0) ? 3000 : 0; pr[k] = 250; end
        load_all();
        run_blk(lat, 0, 0);
        chk_pix("R5 saturate high");
        for (int k = 0; k < 16; k++) begin cf[k] = (k % 3 == 0) ? -3000 : 0; pr[k] = 5; end
        load_all();
        run_blk(lat, 0, 0);
        chk_pix("R5 saturate low");

        // R4/R5: random blocks
        for (int n = 0; n < 120; n++) begin
            for (int k = 0; k < 16; k++) begin
                cf[k] = int'($urandom_range(0, 400)) - 200;
                pr[k] = int'($urandom_range(0, 255));
            end
            if (n % 10 == 0) for (int k = 0; k < 16; k++)
                cf[k] = int'($urandom_range(0, 65535)) - 32768;
            load_all();
            run_blk(lat, 0, 0);
            chk_pix("R4 R5 random block");
        end

        // R8: done holds and pixels stay; a new start clears done
        snap = pix_out;
        repeat (6) @(posedge clk);
        #1;
        chk(done == 1 && pix_out == snap, "R8 done held", int'(done), 1);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        chk(done == 0 && busy == 1, "R8 start clears done", int'(done), 0);
        while (!done) begin @(posedge clk); #1; end

        // R9: stray start mid-run
        for (int k = 0; k < 16; k++) begin cf[k] = k * 7 - 50; pr[k] = 60 + k; end
        load_all();
        run_blk(lat, 4, 0);
        chk(lat == 11, "R9 latency with stray start", lat, 11);
        chk_pix("R9 result with stray start");
        repeat (3) @(posedge clk);
        #1;
        chk(done == 1 && busy == 0, "R9 no second run", int'(busy), 0);

        // R10: stray load mid-run, then rerun without reloading
        run_blk(lat, 0, 6);
        chk_pix("R10 result with stray load");
        run_blk(lat, 0, 0);
        chk_pix("R10 store unchanged");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule